// File: doc/BRIEF.md
# Multicycle Instruction Timing Sequencer

This block is the timing-state controller of a small accumulator machine whose program and data share one single-port memory. Each instruction passes through seven clock states, held in a one-hot register. The first three states fetch the instruction: the program counter goes to the address register, memory is read into the buffer register, and the buffer moves into the instruction register while the program counter steps. The fourth state decodes. The fifth state resolves the operand. An indirect memory-reference instruction reads its effective address from memory in that state. A direct memory-reference instruction waits there. Register and I/O instructions execute there and go straight to the closing state.

The sixth state executes a memory-reference instruction as either an operand read or a store. The seventh state marks completion and checks for an interrupt. If an interrupt is requested and enabled, the program counter is written to a fixed save location, the counter is loaded with a fixed vector, and interrupts are disabled. The sequencer then returns to the first state.

The surrounding datapath decodes the opcode class, the indirect bit and the store bit from its instruction register and feeds them in. It acts on the strobes in the same cycle they appear. The save location and the vector address are constants kept in the datapath.

Top module: `fis_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes step 0 (`t_state` = 7'b0000001) and `ie_flag` becomes 0.
- R2: `t_state` always has exactly one bit set. Bit k set means step k. Steps 0, 1, 2 and 3 always advance to the next step on the following clock.
- R3: Step 0 asserts only `mar_from_pc`. Step 1 asserts only `mbr_load` and `mem_rd`. Step 2 asserts only `ir_load` and `pc_inc`.
- R4: Step 3 (decode) asserts no strobe at all. In particular, neither `mem_rd` nor `mem_wr` is asserted.
- R5: In step 4, with `op_class` = 2'b00 (memory reference) and `ind_bit` = 1, the outputs `mar_from_ir`, `mem_rd` and `ea_load` are asserted, and the next step is 5.
- R6: In step 4, with `op_class` = 2'b00 and `ind_bit` = 0, no strobe is asserted, and the next step is 5.
- R7: In step 4, `op_class` = 2'b01 (register) asserts `exec_reg` and `op_class` = 2'b10 (I/O) asserts `exec_io`. `op_class` = 2'b11 asserts nothing. In all three cases the next step is 6 and step 5 is skipped.
- R8: Step 5 asserts `exec_mem` and `mar_from_ir`, together with `mem_wr` when `store_bit` = 1 or `mem_rd` when `store_bit` = 0. The next step is 6.
- R9: Step 6 asserts `instr_done`, and the next step is 0. If `irq_req` = 1 and `ie_flag` = 1, step 6 also asserts `mar_from_save`, `mem_wr` and `pc_from_vec`, and `ie_flag` is 0 on the next clock. Otherwise no other strobe is asserted.
- R10: `ie_flag` becomes 1 on the clock after `ie_set` is high, unless an interrupt is taken in that cycle, in which case clearing wins. It does not change otherwise. An `irq_req` while `ie_flag` = 0 has no effect on any output.
- R11: `mem_rd` and `mem_wr` are never both high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 2 | Decoded class: 00 memory reference, 01 register, 10 I/O, 11 no operation |
| ind_bit | input | 1 | Indirect-address bit of the current instruction |
| store_bit | input | 1 | Memory-reference instruction writes memory when 1 |
| irq_req | input | 1 | Interrupt request level |
| ie_set | input | 1 | Pulse that enables interrupts |
| t_state | output | 7 | One-hot timing state, bit k = step k |
| mar_from_pc | output | 1 | Load address register from program counter |
| mbr_load | output | 1 | Capture memory read data in buffer register |
| ir_load | output | 1 | Copy buffer register into instruction register |
| pc_inc | output | 1 | Increment program counter |
| mar_from_ir | output | 1 | Drive address from the instruction's address field |
| ea_load | output | 1 | Replace address field with the word read from memory |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| exec_mem | output | 1 | Execute memory-reference operation |
| exec_reg | output | 1 | Execute register operation |
| exec_io | output | 1 | Execute I/O operation |
| mar_from_save | output | 1 | Drive the fixed save location as address |
| pc_from_vec | output | 1 | Load program counter with the fixed vector |
| instr_done | output | 1 | Closing step of the instruction |
| ie_flag | output | 1 | Interrupt enable state |

## Verification
The strobes depend on the current state and on the class, indirect, store and request inputs, so each strobe is due in the same cycle as its step. The state moves one rising edge after the inputs that select it, and `ie_flag` changes one edge after a set pulse or a taken interrupt. The bench applies new inputs just after each falling edge and samples every output 1 ns later. It compares them with a behavioural model that holds the step number and the enable bit. The model then advances exactly as the coming rising edge should. Random class, indirect, store, request and enable patterns run through every branch of step 4 and every interrupt case, and a reset applied in the middle of the run covers R1 again.

// File: rtl/fis_seq_pkg.sv
package fis_seq_pkg;
  localparam int NUM_T     = 7;
  localparam int T_ADDR    = 0;
  localparam int T_READ    = 1;
  localparam int T_IRLD    = 2;
  localparam int T_DEC     = 3;
  localparam int T_RESOLVE = 4;
  localparam int T_EXEC    = 5;
  localparam int T_INTCK   = 6;
  localparam int CLS_W     = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_MEM = 2'b00,
    CLS_REG = 2'b01,
    CLS_IO  = 2'b10,
    CLS_NOP = 2'b11
  } opcls_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mbr_load;
    logic ir_load;
    logic pc_inc;
    logic mar_from_ir;
    logic ea_load;
    logic mem_rd;
    logic mem_wr;
    logic exec_mem;
    logic exec_reg;
    logic exec_io;
    logic mar_from_save;
    logic pc_from_vec;
    logic instr_done;
  } strobes_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer
  import fis_seq_pkg::*;
#(
  parameter int STEPS = NUM_T
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             skip_exec,
  output logic [STEPS-1:0] t_q
);
  localparam logic [STEPS-1:0] FIRST = {{(STEPS-1){1'b0}}, 1'b1};

  logic [STEPS-1:0] t_nxt;

  always_comb begin
    t_nxt = {t_q[STEPS-2:0], t_q[STEPS-1]};
    if (t_q[T_RESOLVE] && skip_exec) begin
      t_nxt = '0;
      t_nxt[T_INTCK] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) t_q <= FIRST;
    else     t_q <= t_nxt;
  end

  assert_onehot_state_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(t_q) == 1);
  assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (rst)
    t_q[T_ADDR] |=> t_q[T_READ]);
  assert_decode_advance_R2: assert property (@(posedge clk) disable iff (rst)
    t_q[T_DEC] |=> t_q[T_RESOLVE]);
  assert_close_to_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    t_q[T_INTCK] |=> t_q[T_ADDR]);
endmodule

// File: rtl/seq_irq.sv
module seq_irq (
  input  logic clk,
  input  logic rst,
  input  logic at_check,
  input  logic irq_req,
  input  logic ie_set,
  output logic ie_q,
  output logic take
);
  assign take = at_check && irq_req && ie_q;

  always_ff @(posedge clk) begin
    if (rst)         ie_q <= 1'b0;
    else if (take)   ie_q <= 1'b0;
    else if (ie_set) ie_q <= 1'b1;
  end

  assert_take_clears_ie_R9: assert property (@(posedge clk) disable iff (rst)
    take |=> !ie_q);
  assert_ie_holds_low_R10: assert property (@(posedge clk) disable iff (rst)
    (!ie_q && !ie_set) |=> !ie_q);
  assert_ie_holds_high_R10: assert property (@(posedge clk) disable iff (rst)
    (ie_q && !take) |=> ie_q);
endmodule

// File: rtl/seq_strobes.sv
module seq_strobes
  import fis_seq_pkg::*;
#(
  parameter int STEPS = NUM_T
) (
  input  logic [STEPS-1:0] t_q,
  input  logic [CLS_W-1:0] op_class,
  input  logic             ind_bit,
  input  logic             store_bit,
  input  logic             take,
  output strobes_t         st
);
  logic is_mem;
  assign is_mem = (op_class == CLS_MEM);

  always_comb begin
    st = '0;
    st.mar_from_pc = t_q[T_ADDR];
    st.mbr_load    = t_q[T_READ];
    st.ir_load     = t_q[T_IRLD];
    st.pc_inc      = t_q[T_IRLD];
    if (t_q[T_RESOLVE]) begin
      st.mar_from_ir = is_mem && ind_bit;
      st.ea_load     = is_mem && ind_bit;
      st.exec_reg    = (op_class == CLS_REG);
      st.exec_io     = (op_class == CLS_IO);
    end
    if (t_q[T_EXEC]) begin
      st.exec_mem    = 1'b1;
      st.mar_from_ir = 1'b1;
    end
    st.mem_rd = t_q[T_READ]
             || (t_q[T_RESOLVE] && is_mem && ind_bit)
             || (t_q[T_EXEC] && !store_bit);
    st.mem_wr = (t_q[T_EXEC] && store_bit) || take;
    st.mar_from_save = take;
    st.pc_from_vec   = take;
    st.instr_done    = t_q[T_INTCK];
  end
endmodule

// File: rtl/fis_sequencer.sv
module fis_sequencer
  import fis_seq_pkg::*;
#(
  parameter int STEPS = NUM_T
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CLS_W-1:0] op_class,
  input  logic             ind_bit,
  input  logic             store_bit,
  input  logic             irq_req,
  input  logic             ie_set,
  output logic [STEPS-1:0] t_state,
  output logic             mar_from_pc,
  output logic             mbr_load,
  output logic             ir_load,
  output logic             pc_inc,
  output logic             mar_from_ir,
  output logic             ea_load,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             exec_mem,
  output logic             exec_reg,
  output logic             exec_io,
  output logic             mar_from_save,
  output logic             pc_from_vec,
  output logic             instr_done,
  output logic             ie_flag
);
  logic [STEPS-1:0] t_q;
  logic             take;
  logic             skip_exec;
  strobes_t         st;

  assign skip_exec = (op_class != CLS_MEM);

  seq_timer #(.STEPS(STEPS)) u_timer (
    .clk(clk), .rst(rst), .skip_exec(skip_exec), .t_q(t_q)
  );

  seq_irq u_irq (
    .clk(clk), .rst(rst), .at_check(t_q[T_INTCK]), .irq_req(irq_req),
    .ie_set(ie_set), .ie_q(ie_flag), .take(take)
  );

  seq_strobes #(.STEPS(STEPS)) u_strobes (
    .t_q(t_q), .op_class(op_class), .ind_bit(ind_bit),
    .store_bit(store_bit), .take(take), .st(st)
  );

  assign t_state       = t_q;
  assign mar_from_pc   = st.mar_from_pc;
  assign mbr_load      = st.mbr_load;
  assign ir_load       = st.ir_load;
  assign pc_inc        = st.pc_inc;
  assign mar_from_ir   = st.mar_from_ir;
  assign ea_load       = st.ea_load;
  assign mem_rd        = st.mem_rd;
  assign mem_wr        = st.mem_wr;
  assign exec_mem      = st.exec_mem;
  assign exec_reg      = st.exec_reg;
  assign exec_io       = st.exec_io;
  assign mar_from_save = st.mar_from_save;
  assign pc_from_vec   = st.pc_from_vec;
  assign instr_done    = st.instr_done;

  assert_decode_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    t_q[T_DEC] |-> !(mem_rd || mem_wr));
  assert_rd_wr_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  assert_skip_exec_R7: assert property (@(posedge clk) disable iff (rst)
    (t_q[T_RESOLVE] && op_class != CLS_MEM) |=> t_q[T_INTCK]);
  assert_mem_to_exec_R5: assert property (@(posedge clk) disable iff (rst)
    (t_q[T_RESOLVE] && op_class == CLS_MEM) |=> t_q[T_EXEC]);
  assert_vector_writes_R9: assert property (@(posedge clk) disable iff (rst)
    pc_from_vec |-> (mem_wr && instr_done));
endmodule

// File: tb/fis_sequencer_test.sv
`timescale 1ns/100ps
module fis_sequencer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op_class = 2'b00;
  logic       ind_bit = 1'b0, store_bit = 1'b0, irq_req = 1'b0, ie_set = 1'b0;
  logic [6:0] t_state;
  logic mar_from_pc, mbr_load, ir_load, pc_inc, mar_from_ir, ea_load, mem_rd, mem_wr;
  logic exec_mem, exec_reg, exec_io, mar_from_save, pc_from_vec, instr_done, ie_flag;

  int  n_cmp = 0;
  int  n_bad = 0;
  int  m_st = 0;
  bit  m_ie = 1'b0;
  bit  started = 1'b0;
  bit  finished = 1'b0;
  int  cyc = 0;

  always #2.5 clk = ~clk;

  fis_sequencer uut (
    .clk(clk), .rst(rst), .op_class(op_class), .ind_bit(ind_bit),
    .store_bit(store_bit), .irq_req(irq_req), .ie_set(ie_set),
    .t_state(t_state), .mar_from_pc(mar_from_pc), .mbr_load(mbr_load),
    .ir_load(ir_load), .pc_inc(pc_inc), .mar_from_ir(mar_from_ir),
    .ea_load(ea_load), .mem_rd(mem_rd), .mem_wr(mem_wr), .exec_mem(exec_mem),
    .exec_reg(exec_reg), .exec_io(exec_io), .mar_from_save(mar_from_save),
    .pc_from_vec(pc_from_vec), .instr_done(instr_done), .ie_flag(ie_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected strobes, bit order: pc>mar, mbr, ir, pc+1, ir>mar, ea, rd, wr,
  // exec_mem, exec_reg, exec_io, save>mar, vec>pc, done
  function automatic logic [13:0] expect_strobes(input int s, input logic [1:0] c,
      input logic i, input logic w, input logic q, input bit ie);
    logic [13:0] e;
    e = '0;
    case (s)
      0: e[13] = 1'b1;                                   // R3
      1: begin e[12] = 1'b1; e[7] = 1'b1; end            // R3
      2: begin e[11] = 1'b1; e[10] = 1'b1; end           // R3
      3: ;                                               // R4
      4: begin
        if (c == 2'b00 && i) begin e[9] = 1'b1; e[8] = 1'b1; e[7] = 1'b1; end // R5
        if (c == 2'b01) e[4] = 1'b1;                     // R7
        if (c == 2'b10) e[3] = 1'b1;                     // R7
      end
      5: begin
        e[5] = 1'b1; e[9] = 1'b1;                        // R8
        if (w) e[6] = 1'b1; else e[7] = 1'b1;
      end
      default: begin
        e[0] = 1'b1;                                     // R9
        if (q && ie) begin e[2] = 1'b1; e[1] = 1'b1; e[6] = 1'b1; end
      end
    endcase
    return e;
  endfunction

  function automatic string step_tag(input int s, input logic [1:0] c, input logic i);
    case (s)
      0, 1, 2: return "R3";
      3:       return "R4";
      4:       return (c == 2'b00) ? (i ? "R5" : "R6") : "R7";
      5:       return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input logic r, input logic [1:0] c, input logic i,
      input logic w, input logic q, input logic e);
    logic [13:0] act;
    logic [13:0] exp;
    bit take;
    @(negedge clk);
    rst = r; op_class = c; ind_bit = i; store_bit = w; irq_req = q; ie_set = e;
    #1;
    if (started) begin
      act = {mar_from_pc, mbr_load, ir_load, pc_inc, mar_from_ir, ea_load, mem_rd,
             mem_wr, exec_mem, exec_reg, exec_io, mar_from_save, pc_from_vec, instr_done};
      exp = expect_strobes(m_st, c, i, w, q, m_ie);
      chk(m_st == 0 && cyc < 6 ? "R1" : "R2", {25'd0, t_state}, 32'd1 << m_st);
      chk(step_tag(m_st, c, i), {18'd0, act}, {18'd0, exp});
      chk(m_st == 6 ? "R9" : "R10", {31'd0, ie_flag}, {31'd0, m_ie});
      chk("R11", {31'd0, mem_rd & mem_wr}, 32'd0);
    end
    // advance the model as the coming rising edge should
    take = (m_st == 6) && q && m_ie;
    if (r) begin
      m_st = 0; m_ie = 1'b0;
    end else begin
      if (take) m_ie = 1'b0;
      else if (e) m_ie = 1'b1;
      case (m_st)
        4:       m_st = (c == 2'b00) ? 5 : 6;
        6:       m_st = 0;
        default: m_st = m_st + 1;
      endcase
    end
    started = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected<=150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset held for three cycles
    repeat (3) step(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
    // directed: one instruction of each kind with interrupts off (R10 ignore)
    repeat (7) step(1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0); // R5 indirect read
    repeat (7) step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0); // R6 direct store
    repeat (6) step(1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0); // R7 register
    repeat (6) step(1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0); // R7 I/O
    repeat (6) step(1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0); // R7 no-op
    // R10 set enable, R9 take an interrupt with enable pulse held (clear wins)
    step(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (12) step(1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1);
    // random patterns
    for (int k = 0; k < 4000; k++) begin
      step(k == 2000 || k == 2001, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 15) == 0));
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule